// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a host access to a small configuration register file over a byte-wide bus with two addresses. The low address is the pointer port: a write there picks which configuration register is addressed. The high address is the data port: reads and writes there reach the register the pointer selects. Decoding the actual base address is left to the surrounding logic. That logic presents the offset as a single select bit, where 0 is the pointer port and 1 is the data port.

On reset the register file is sealed. To open it, the host writes the opening key 0x87 to the pointer port twice in a row. Writing 0xAA to the pointer port seals it again. While the file is open, pointer values below 0x30 reach global registers:

- the device-select byte at 0x07;
- a read-only 16-bit identifier at 0x20 (high byte) and 0x21 (low byte);
- six option bytes.

Pointer values 0x30, 0xE0, 0xE1 and 0xE2 reach a bank of four bytes. Each logical device has its own bank, and the device-select byte chooses which bank these pointers reach.

Top module: `cfg_key_port`

## Requirements
- R1: A synchronous active-high `rst` seals the file and clears the device select, every option byte and every bank byte to 0x00.
- R2: The file opens on the clock edge that takes the second of two consecutive pointer-port writes of 0x87.
- R3: A pointer-port write of any value other than 0x87 while sealed discards a pending first key, so a further two 0x87 writes are needed.
- R4: While sealed, data-port reads return 0xFF. Data-port writes change no register, and they neither advance nor cancel the key sequence.
- R5: While open, a pointer-port write of 0xAA seals the file and does not change any register contents.
- R6: Pointer 0x20 reads 0xA2 and pointer 0x21 reads {0x3, CHIP_REV}, which is 0x31 by default. Writes to either pointer are dropped.
- R7: Option bytes at pointers 0x22, 0x23, 0x24, 0x29, 0x2A and 0x2C can be read and written, and each holds its value whatever device is selected.
- R8: Pointer 0x07 holds the device select. Pointers 0x30, 0xE0, 0xE1 and 0xE2 reach the bank of the selected device, and each device keeps its own values.
- R9: Any other pointer reads 0x00 and ignores writes. When the device select is NUM_DEV or higher, the bank pointers read 0x00 and ignore writes.
- R10: A pointer-port read returns the current pointer while the file is open, and 0xFF while it is sealed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | 0 selects the pointer port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port; combinational, with no side effects |

## Verification
The read path is combinational, so a fault in the key state machine shows on the data port in the very next cycle. A key sequence that opens too early returns stored values where 0xFF is due. One that fails to open keeps returning 0xFF.

A wrong bank address or a wrong device select surfaces only when a different device is selected and its bank is read back. For that reason the stimulus writes distinct values into two banks and alternates between them.

A register that survives reset, or that takes a write while the file is sealed, shows up on the first readback after the file is reopened.

// File: rtl/cfg_key_port.sv
module cfg_key_port #(
  parameter logic [3:0] CHIP_REV  = 4'h1,
  parameter int         NUM_DEV   = 16,
  parameter logic [7:0] KEY_OPEN  = 8'h87,
  parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam logic [15:0] CHIP_ID = {12'hA23, CHIP_REV};
  localparam int NBANK = 4;
  localparam int NGLOB = 6;
  localparam int NSLOT = NUM_DEV * NBANK;
  localparam int AW    = $clog2(NSLOT);

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_OPEN} key_t;

  key_t       key_st;
  logic [7:0] idx, ld;
  logic [7:0] glob [NGLOB];
  logic [7:0] bank [NSLOT];

  logic          g_hit, b_hit, ld_ok;
  logic [2:0]    g_sel;
  logic [1:0]    b_sel;
  logic [AW-1:0] baddr;
  logic [7:0]    rd_val;

  wire is_open = (key_st == K_OPEN);
  wire idx_wr  = wr_en && !port_sel;
  wire dat_wr  = wr_en && port_sel && is_open;

  always_comb begin
    g_hit = 1'b1;
    g_sel = 3'd0;
    case (idx)
      8'h22: g_sel = 3'd0;
      8'h23: g_sel = 3'd1;
      8'h24: g_sel = 3'd2;
      8'h29: g_sel = 3'd3;
      8'h2A: g_sel = 3'd4;
      8'h2C: g_sel = 3'd5;
      default: g_hit = 1'b0;
    endcase
    b_hit = 1'b1;
    b_sel = 2'd0;
    case (idx)
      8'h30: b_sel = 2'd0;
      8'hE0: b_sel = 2'd1;
      8'hE1: b_sel = 2'd2;
      8'hE2: b_sel = 2'd3;
      default: b_hit = 1'b0;
    endcase
    ld_ok = int'(ld) < NUM_DEV;
    baddr = AW'(int'(ld) * NBANK + int'(b_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_st <= K_IDLE;
      idx    <= 8'h00;
      ld     <= 8'h00;
      for (int i = 0; i < NGLOB; i++) glob[i] <= 8'h00;
      for (int i = 0; i < NSLOT; i++) bank[i] <= 8'h00;
    end else begin
      if (idx_wr) begin
        case (key_st)
          K_IDLE:  key_st <= (wdata == KEY_OPEN) ? K_HALF : K_IDLE;
          K_HALF:  key_st <= (wdata == KEY_OPEN) ? K_OPEN : K_IDLE;
          default: begin
            if (wdata == KEY_CLOSE) key_st <= K_IDLE;
            else idx <= wdata;
          end
        endcase
      end
      if (dat_wr) begin
        if (idx == 8'h07) ld <= wdata;
        else if (g_hit) glob[g_sel] <= wdata;
        else if (b_hit && ld_ok) bank[baddr] <= wdata;
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (idx == 8'h07) rd_val = ld;
    else if (idx == 8'h20) rd_val = CHIP_ID[15:8];
    else if (idx == 8'h21) rd_val = CHIP_ID[7:0];
    else if (g_hit) rd_val = glob[g_sel];
    else if (b_hit && ld_ok) rd_val = bank[baddr];
  end

  assign rdata = !is_open ? 8'hFF : (port_sel ? rd_val : idx);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (key_st == K_IDLE && ld == 8'h00));

  p_unlock_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(is_open) |-> $past(idx_wr && wdata == KEY_OPEN));

  p_badkey_r3: assert property (@(posedge clk) disable iff (rst)
    (!is_open && idx_wr && wdata != KEY_OPEN) |=> (key_st == K_IDLE));

  p_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (!is_open && wr_en && port_sel) |=> ($stable(ld) && $stable(idx) && $stable(key_st)));

  p_close_r5: assert property (@(posedge clk) disable iff (rst)
    (is_open && idx_wr && wdata == KEY_CLOSE) |=> (!is_open && $stable(ld)));

  p_idro_r6: assert property (@(posedge clk) disable iff (rst)
    (is_open && port_sel && idx == 8'h20) |-> (rdata == CHIP_ID[15:8]));

  p_ldhold_r8: assert property (@(posedge clk) disable iff (rst)
    !(dat_wr && idx == 8'h07) |=> $stable(ld));
endmodule

// File: tb/sim_cfg_key_port.sv
module sim_cfg_key_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_sel = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfg_key_port u0 (.clk(clk), .rst(rst), .port_sel(port_sel), .wr_en(wr_en),
                   .wdata(wdata), .rdata(rdata));

  // {write, data_port, req, wdata, expected}
  localparam int NV = 63;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b1,4'd4, 8'h00,8'hFF}, // R4 sealed data read
    {1'b0,1'b0,4'd10,8'h00,8'hFF}, // R10 sealed pointer read
    {1'b1,1'b0,4'd4, 8'h24,8'h00},
    {1'b1,1'b1,4'd4, 8'h5A,8'h00}, // R4 dropped write
    {1'b1,1'b0,4'd3, 8'h87,8'h00}, // R3 key, break, key
    {1'b1,1'b0,4'd3, 8'h00,8'h00},
    {1'b1,1'b0,4'd3, 8'h87,8'h00},
    {1'b0,1'b1,4'd3, 8'h00,8'hFF},
    {1'b1,1'b0,4'd2, 8'h87,8'h00}, // R2 second key opens
    {1'b1,1'b0,4'd10,8'h24,8'h00},
    {1'b0,1'b0,4'd10,8'h00,8'h24},
    {1'b0,1'b1,4'd4, 8'h00,8'h00},
    {1'b1,1'b1,4'd7, 8'h5A,8'h00}, // R7
    {1'b0,1'b1,4'd7, 8'h00,8'h5A},
    {1'b1,1'b0,4'd6, 8'h20,8'h00}, // R6
    {1'b0,1'b1,4'd6, 8'h00,8'hA2},
    {1'b1,1'b0,4'd6, 8'h21,8'h00},
    {1'b0,1'b1,4'd6, 8'h00,8'h31},
    {1'b1,1'b1,4'd6, 8'h00,8'h00},
    {1'b0,1'b1,4'd6, 8'h00,8'h31},
    {1'b1,1'b0,4'd8, 8'h07,8'h00}, // R8
    {1'b0,1'b1,4'd1, 8'h00,8'h00}, // R1 select starts at 0
    {1'b1,1'b0,4'd8, 8'h30,8'h00},
    {1'b1,1'b1,4'd8, 8'h11,8'h00},
    {1'b1,1'b0,4'd8, 8'h07,8'h00},
    {1'b1,1'b1,4'd8, 8'h03,8'h00},
    {1'b1,1'b0,4'd8, 8'h30,8'h00},
    {1'b0,1'b1,4'd8, 8'h00,8'h00},
    {1'b1,1'b1,4'd8, 8'h33,8'h00},
    {1'b1,1'b0,4'd8, 8'hE1,8'h00},
    {1'b1,1'b1,4'd8, 8'h3E,8'h00},
    {1'b1,1'b0,4'd8, 8'h07,8'h00},
    {1'b1,1'b1,4'd8, 8'h00,8'h00},
    {1'b1,1'b0,4'd8, 8'h30,8'h00},
    {1'b0,1'b1,4'd8, 8'h00,8'h11},
    {1'b1,1'b0,4'd8, 8'hE1,8'h00},
    {1'b0,1'b1,4'd8, 8'h00,8'h00},
    {1'b1,1'b0,4'd8, 8'h07,8'h00},
    {1'b1,1'b1,4'd8, 8'h03,8'h00},
    {1'b1,1'b0,4'd8, 8'hE1,8'h00},
    {1'b0,1'b1,4'd8, 8'h00,8'h3E},
    {1'b1,1'b0,4'd7, 8'h24,8'h00},
    {1'b0,1'b1,4'd7, 8'h00,8'h5A},
    {1'b1,1'b0,4'd9, 8'h40,8'h00}, // R9
    {1'b1,1'b1,4'd9, 8'h77,8'h00},
    {1'b0,1'b1,4'd9, 8'h00,8'h00},
    {1'b1,1'b0,4'd9, 8'h07,8'h00},
    {1'b1,1'b1,4'd9, 8'h20,8'h00},
    {1'b1,1'b0,4'd9, 8'h30,8'h00},
    {1'b1,1'b1,4'd9, 8'h99,8'h00},
    {1'b0,1'b1,4'd9, 8'h00,8'h00},
    {1'b1,1'b0,4'd9, 8'h07,8'h00},
    {1'b0,1'b1,4'd9, 8'h00,8'h20},
    {1'b1,1'b0,4'd5, 8'hAA,8'h00}, // R5
    {1'b0,1'b1,4'd5, 8'h00,8'hFF},
    {1'b0,1'b0,4'd5, 8'h00,8'hFF},
    {1'b1,1'b0,4'd2, 8'h87,8'h00},
    {1'b1,1'b0,4'd2, 8'h87,8'h00},
    {1'b1,1'b0,4'd5, 8'h24,8'h00},
    {1'b0,1'b1,4'd5, 8'h00,8'h5A},
    {1'b1,1'b0,4'd7, 8'h2C,8'h00},
    {1'b1,1'b1,4'd7, 8'hC3,8'h00},
    {1'b0,1'b1,4'd7, 8'h00,8'hC3}
  };

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    port_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic sel, input logic [7:0] exp, input int req);
    @(negedge clk);
    port_sel = sel;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL R%0d: rdata=%02h expected=%02h", req, rdata, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20], VEC[i][15:8]);
      else chk(VEC[i][20], VEC[i][7:0], int'(VEC[i][19:16]));
    end

    // R1: reset in the middle of a session
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(1'b1, 8'hFF, 1);
    chk(1'b0, 8'hFF, 1);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    wr(1'b0, 8'h07); chk(1'b1, 8'h00, 1);
    wr(1'b0, 8'h2C); chk(1'b1, 8'h00, 1);
    wr(1'b0, 8'h30); chk(1'b1, 8'h00, 1);

    // R4: a data write between the keys neither breaks nor completes the sequence
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h87);
    wr(1'b1, 8'h55);
    chk(1'b1, 8'hFF, 4);
    wr(1'b0, 8'h87);
    wr(1'b0, 8'h30); chk(1'b1, 8'h00, 4);

    // R3: a single key followed by another value leaves the file sealed
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h87); wr(1'b0, 8'h86); wr(1'b0, 8'h87);
    chk(1'b1, 8'hFF, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule